// File: doc/BRIEF.md
# Burst Address Sequencer with Selectable Stepping Order

This block produces the address that a synchronous burst memory presents to its storage array. A burst begins when either of two active-low start strobes is accepted. The external address is then captured whole. Each later cycle with the advance strobe low moves a two-bit beat counter forward. The low two address bits come from the captured start bits and that count, so a burst covers four words in a 2-1-1-1 pattern. The upper bits stay at their captured value until the next start.

The stepping order is chosen by an order-select input. Linear order adds the count to the start bits modulo four. Interleaved order XORs the count into the start bits. The order is latched at each burst start, so a change on the pin takes effect only at the next start. A fresh address can be loaded on any cycle, so callers that never advance get plain single-address operation.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is high at a clock edge, the block clears the captured address, the beat count and the latched order, so after reset `addr_out` is all zeros.
- R2: When `start_cpu_n` is 0 and `ce_n` is 0 at a rising edge, `addr_out` equals the sampled `addr_in` right after that edge.
- R3: When `start_cpu_n` is 0 while `ce_n` is 1 and `start_ctl_n` is 1, the strobe is ignored and the cycle behaves as if `start_cpu_n` were 1.
- R4: When `start_ctl_n` is 0 at a rising edge, `addr_in` is loaded whatever the level of `ce_n`.
- R5: An edge with `adv_n` at 0 and no accepted start advances the beat count by one, and the bits above bit 1 of `addr_out` stay unchanged.
- R6: With `order_sel` at 1 when the burst started (linear), the low two bits of `addr_out` equal (start bits + count) mod 4.
- R7: With `order_sel` at 0 when the burst started (interleaved), the low two bits of `addr_out` equal start bits XOR count.
- R8: An edge with `adv_n` at 1 and no accepted start leaves `addr_out` unchanged.
- R9: An accepted start overrides a simultaneous advance: the new address is loaded and the count returns to 0.
- R10: `order_sel` is sampled only on an accepted start, and a change during a burst has no effect on the current burst.
- R11: After four advances, the count wraps and `addr_out` returns to the burst's first address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | AW | External address |
| start_cpu_n | input | 1 | Processor-side burst start, active low, qualified by `ce_n` |
| start_ctl_n | input | 1 | Controller-side burst start, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Chip-enable qualifier, active low |
| order_sel | input | 1 | 1 selects linear order, 0 selects interleaved order |
| addr_out | output | AW | Current internal address to the array |

## Verification
The hardest situation to reach is a mid-burst change of `order_sel`. The change must leave the running sequence alone while the next start picks up the new setting. The bench toggles the pin between advances and then checks later beats against the order latched at the start. The ignored processor start is also easy to miss. The bench combines it with a simultaneous advance, so that a wrong load would show up as a different address rather than being hidden by a hold.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int CNT_W = 2;

    typedef logic [CNT_W-1:0] beat_t;

    typedef enum logic {
        ORD_ILV = 1'b0,
        ORD_LIN = 1'b1
    } burst_order_e;

    typedef struct packed {
        logic load;
        logic adv;
    } seq_ctrl_t;

    function automatic beat_t map_beat(burst_order_e ord, beat_t first, beat_t cnt);
        beat_t sum;
        sum = first + cnt;
        return (ord == ORD_LIN) ? sum : (first ^ cnt);
    endfunction

endpackage

// File: rtl/burst_ctrl_decode.sv
module burst_ctrl_decode
    import burst_seq_pkg::*;
(
    input  logic      start_cpu_n,
    input  logic      start_ctl_n,
    input  logic      adv_n,
    input  logic      ce_n,
    output seq_ctrl_t ctrl
);
    logic cpu_ok;

    always_comb begin
        cpu_ok    = !start_cpu_n && !ce_n;
        ctrl.load = cpu_ok || !start_ctl_n;
        ctrl.adv  = !adv_n && !ctrl.load;
    end

    always_comb begin
        assert (!(ctrl.load && ctrl.adv)) else $error("assert_excl_R9 failed");
    end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
    import burst_seq_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [AW-1:0] addr_in,
    input  logic         order_in,
    output logic [AW-1:0] base_q,
    output burst_order_e order_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            order_q <= ORD_ILV;
        end else if (load) begin
            base_q  <= addr_in;
            order_q <= burst_order_e'(order_in);
        end
    end

    assert_order_R10: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(order_q));
    assert_base_R5: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(base_q));
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
    import burst_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  adv,
    output beat_t cnt_q
);
    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= '0;
        else if (adv)  cnt_q <= cnt_q + beat_t'(1);
    end

    assert_step_R5: assert property (@(posedge clk) disable iff (rst)
        adv |=> cnt_q == beat_t'($past(cnt_q) + beat_t'(1)));
    assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt_q == '0);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr_in,
    input  logic          start_cpu_n,
    input  logic          start_ctl_n,
    input  logic          adv_n,
    input  logic          ce_n,
    input  logic          order_sel,
    output logic [AW-1:0] addr_out
);
    localparam int UP_W = AW - CNT_W;

    seq_ctrl_t    ctrl;
    logic [AW-1:0] base_q;
    burst_order_e order_q;
    beat_t        cnt_q;

    burst_ctrl_decode u_dec (
        .start_cpu_n (start_cpu_n),
        .start_ctl_n (start_ctl_n),
        .adv_n       (adv_n),
        .ce_n        (ce_n),
        .ctrl        (ctrl)
    );

    burst_base_reg #(.AW(AW)) u_base (
        .clk      (clk),
        .rst      (rst),
        .load     (ctrl.load),
        .addr_in  (addr_in),
        .order_in (order_sel),
        .base_q   (base_q),
        .order_q  (order_q)
    );

    burst_beat_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .load  (ctrl.load),
        .adv   (ctrl.adv),
        .cnt_q (cnt_q)
    );

    generate
        if (UP_W > 0) begin : g_upper
            assign addr_out = {base_q[AW-1:CNT_W], map_beat(order_q, base_q[CNT_W-1:0], cnt_q)};
        end else begin : g_low_only
            assign addr_out = map_beat(order_q, base_q[CNT_W-1:0], cnt_q);
        end
    endgenerate

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (!start_cpu_n && !ce_n) |=> addr_out == $past(addr_in));
    assert_ctl_R4: assert property (@(posedge clk) disable iff (rst)
        !start_ctl_n |=> addr_out == $past(addr_in));
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (adv_n && start_ctl_n && (start_cpu_n || ce_n)) |=> $stable(addr_out));
    assert_ignore_R3: assert property (@(posedge clk) disable iff (rst)
        (!start_cpu_n && ce_n && start_ctl_n && adv_n) |=> $stable(addr_out));
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr_in;
    logic          start_cpu_n, start_ctl_n, adv_n, ce_n, order_sel;
    logic [AW-1:0] addr_out;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic [AW-1:0] mb;
    int            mc;
    bit            mo;

    always #5 clk = ~clk;

    burst_addr_seq #(.AW(AW)) i_burst_addr_seq (
        .clk(clk), .rst(rst), .addr_in(addr_in),
        .start_cpu_n(start_cpu_n), .start_ctl_n(start_ctl_n),
        .adv_n(adv_n), .ce_n(ce_n), .order_sel(order_sel),
        .addr_out(addr_out)
    );

    function automatic logic [AW-1:0] model_addr();
        int lo;
        lo = mo ? ((int'(mb[1:0]) + mc) % 4) : (int'(mb[1:0]) ^ mc);
        return {mb[AW-1:2], 2'(lo)};
    endfunction

    task automatic check(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic cyc(input bit cpu, input bit ctl, input bit adv, input bit ce,
                       input logic [AW-1:0] a, input bit lin);
        @(negedge clk);
        start_cpu_n = cpu; start_ctl_n = ctl; adv_n = adv; ce_n = ce;
        addr_in = a; order_sel = lin;
        @(posedge clk);
        #1;
        if ((!cpu && !ce) || !ctl) begin
            mb = a; mc = 0; mo = lin;
        end else if (!adv) begin
            mc = (mc + 1) % 4;
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] a;
        rst = 1'b1; start_cpu_n = 1; start_ctl_n = 1; adv_n = 1; ce_n = 1;
        order_sel = 1; addr_in = 8'hFF;
        mb = '0; mc = 0; mo = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", addr_out, 8'h00);
        @(negedge clk); rst = 1'b0;

        // exhaustive: every start offset, both orders, five beats
        for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < 2; o++) begin
                a = 8'(((s * 13 + o * 5 + 3) << 2) | s);
                cyc(0, 1, 1, 0, a, o[0]);
                check("R2", addr_out, a);
                for (int k = 1; k <= 4; k++) begin
                    cyc(1, 1, 0, 0, 8'h00, o[0]);
                    check(o ? "R6" : "R7", addr_out, model_addr());
                    check("R5", {addr_out[AW-1:2], 2'b00}, {a[AW-1:2], 2'b00});
                    if (k == 4) check("R11", addr_out, a);
                end
            end
        end

        // hold with advance high
        cyc(1, 1, 0, 0, 8'h00, 1);
        a = addr_out;
        cyc(1, 1, 1, 0, 8'h5A, 1);
        check("R8", addr_out, a);
        cyc(1, 1, 1, 1, 8'h33, 0);
        check("R8", addr_out, model_addr());

        // processor start ignored with ce high, combined with advance
        cyc(0, 1, 1, 1, 8'hC4, 1);
        check("R3", addr_out, a);
        cyc(0, 1, 0, 1, 8'hC4, 1);
        check("R3", addr_out, model_addr());

        // controller start loads with ce high and low
        cyc(1, 0, 1, 1, 8'h9D, 0);
        check("R4", addr_out, 8'h9D);
        cyc(1, 0, 1, 0, 8'h26, 1);
        check("R4", addr_out, 8'h26);

        // start overrides advance
        cyc(1, 1, 0, 0, 8'h00, 1);
        cyc(0, 1, 0, 0, 8'h71, 0);
        check("R9", addr_out, 8'h71);
        cyc(1, 0, 0, 1, 8'hE2, 1);
        check("R9", addr_out, 8'hE2);

        // order change mid-burst has no effect until next start
        cyc(0, 1, 1, 0, 8'h41, 0);
        cyc(1, 1, 0, 0, 8'h00, 1);
        check("R10", addr_out, 8'h40);
        cyc(1, 1, 0, 0, 8'h00, 1);
        check("R10", addr_out, 8'h43);
        cyc(0, 1, 1, 0, 8'h41, 1);
        cyc(1, 1, 0, 0, 8'h00, 0);
        check("R10", addr_out, 8'h42);
        check("R6", addr_out, model_addr());

        // reset mid-burst
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check("R1", addr_out, 8'h00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule